// File: doc/BRIEF.md
# Prefetching Host Read/Write Word Queues

This block sits between a host data port and a memory engine. It holds two eight-word queues. Host data writes go into the write queue. When enough words are waiting, the block sends them to memory as a burst. Host reads with address autoincrement are served from the read queue. The block fills that queue ahead of the host with four-word prefetch bursts.

The host presents one operation at a time on `h_req`/`h_op` and holds it until `h_ready` is high. The operations are:
- a data write;
- an autoincrement read;
- a single-word read;
- loading the write address;
- loading the read address.

The memory side carries one command at a time, which is an address, a length and a direction. The command is held until it is granted. One data beat then moves per `m_beat` pulse. Flush conditions let in-flight transfers finish before queued data is dropped or drained, so the host never receives stale words.

Top module: `hostq_prefetch`

## Requirements
- R1: The write queue holds at most DEPTH (8) words. A data write (op 0) gets `h_ready` low while the queue is full.
- R2: When the write queue holds at least BURST (4) words, a write command of length 4 is issued at the write address. The write address then advances by the burst length, and the words reach memory in push order.
- R3: A load-write-address (op 3) or a read (op 1 or 2) waits while the write queue holds words. The remaining words (fewer than 4) are first written to memory as one shorter burst, at the current write address.
- R4: An autoincrement read (op 1) on an empty, idle read queue arms prefetch. Two read commands of length 4 follow at consecutive addresses starting from the read address, filling all 8 entries.
- R5: While prefetch is armed, a further length-4 read command is issued each time at least 4 read-queue entries are free.
- R6: An autoincrement read returns `h_ready` low until the read queue holds data. Accepted reads return consecutive memory words in address order.
- R7: A load-read-address (op 4) waits until no read burst is in flight, then discards the read queue and disarms prefetch. The next read returns data from the new address.
- R8: A single read (op 2) issues one length-1 read at the next host read address and returns that word. It discards the read queue, disarms prefetch and leaves the host read address unchanged.
- R9: `m_req` stays high until `m_gnt`, with `m_addr`, `m_len` and `m_we` unchanged while waiting. `m_we` is 1 for writes.
- R10: After reset no memory command is pending and both queues are empty.
- R11: Op codes are 0 data write, 1 autoincrement read, 2 single read, 3 load write address and 4 load read address; addresses count words. The write data or address is on `h_wdata`, and read data is valid on `h_rdata` in the cycle `h_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host operation present |
| h_op | input | 3 | Host operation code (R11) |
| h_wdata | input | DW | Write data or address to load |
| h_ready | output | 1 | Operation accepted this cycle |
| h_rdata | output | DW | Read data, valid with `h_ready` |
| m_req | output | 1 | Memory command pending |
| m_we | output | 1 | Command direction, 1 = write |
| m_addr | output | AW | Command start word address |
| m_len | output | $clog2(BURST+1) | Command length in words |
| m_gnt | input | 1 | Command granted |
| m_beat | input | 1 | One data word moves this cycle |
| m_wdata | output | DW | Write data for the current beat |
| m_rdata | input | DW | Read data for the current beat |

## Verification
The bench first reads back words it just wrote through the queue. A design that let reads overtake the partial write drain would return the old memory contents. It then follows a single read with an autoincrement read. This catches a design that advances the host read address on the single read, or that keeps prefetched words after it, because the next word would be skipped or stale. The bench counts prefetch commands at a fresh address. A wrong refill threshold shows up as one burst too many or too few. Finally it fills the write queue while grants are withheld. This shows whether a ninth write is refused and whether a waiting command holds still.

// File: rtl/hostq_prefetch.sv
module hostq_prefetch #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int BURST = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       h_req,
  input  logic [2:0]                 h_op,
  input  logic [DW-1:0]              h_wdata,
  output logic                       h_ready,
  output logic [DW-1:0]              h_rdata,
  output logic                       m_req,
  output logic                       m_we,
  output logic [AW-1:0]              m_addr,
  output logic [$clog2(BURST+1)-1:0] m_len,
  input  logic                       m_gnt,
  input  logic                       m_beat,
  output logic [DW-1:0]              m_wdata,
  input  logic [DW-1:0]              m_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(BURST + 1);

  typedef enum logic [1:0] {E_IDLE, E_REQ, E_BUSY} est_t;

  logic [DW-1:0] wq [DEPTH];
  logic [DW-1:0] rq [DEPTH];
  logic [PW-1:0] wq_wp, wq_rp, rq_wp, rq_rp;
  logic [CW-1:0] wf_cnt, rf_cnt;
  logic [AW-1:0] waddr, ra_host, ra_fetch;
  logic [LW-1:0] left;
  logic          pf_on, single, s_done;
  logic [DW-1:0] s_data;
  est_t          st;

  wire op_wr  = h_op == 3'd0;
  wire op_rdi = h_op == 3'd1;
  wire op_rds = h_op == 3'd2;
  wire op_ldw = h_op == 3'd3;
  wire op_ldr = h_op == 3'd4;

  wire wr_busy = (st != E_IDLE) && m_we;
  wire drained = (wf_cnt == '0) && !wr_busy;
  logic rdy;
  always_comb begin
    rdy = 1'b0;
    if (op_wr)  rdy = wf_cnt != CW'(DEPTH);
    if (op_rdi) rdy = drained && (rf_cnt != '0);
    if (op_rds) rdy = s_done;
    if (op_ldw) rdy = drained;
    if (op_ldr) rdy = st == E_IDLE;
  end
  assign h_ready = h_req && rdy;
  assign h_rdata = op_rds ? s_data : rq[rq_rp];

  wire acc_wr  = h_ready && op_wr;
  wire acc_rdi = h_ready && op_rdi;
  wire acc_rds = h_ready && op_rds;
  wire acc_ldw = h_ready && op_ldw;
  wire acc_ldr = h_ready && op_ldr;

  wire drain_req = h_req && (op_rdi || op_rds || op_ldw) && (wf_cnt != '0);
  wire go_w = (st == E_IDLE) && ((wf_cnt >= CW'(BURST)) || drain_req);
  wire go_s = (st == E_IDLE) && !go_w && h_req && op_rds && !s_done && (wf_cnt == '0);
  wire go_p = (st == E_IDLE) && !go_w && !go_s && pf_on &&
              (rf_cnt <= CW'(DEPTH - BURST)) && !(h_req && (op_ldr || op_rds));
  wire [LW-1:0] wlen = (wf_cnt >= CW'(BURST)) ? LW'(BURST) : LW'(wf_cnt);

  wire beat   = (st == E_BUSY) && m_beat;
  wire pop_w  = beat && m_we;
  wire push_r = beat && !m_we && !single;
  wire flush_r = acc_ldr || go_s;

  assign m_req   = st == E_REQ;
  assign m_wdata = wq[wq_rp];

  always_ff @(posedge clk) begin
    if (acc_wr) wq[wq_wp] <= h_wdata;
    if (push_r) rq[rq_wp] <= m_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq_wp <= '0; wq_rp <= '0; wf_cnt <= '0;
      rq_wp <= '0; rq_rp <= '0; rf_cnt <= '0;
      waddr <= '0; ra_host <= '0; ra_fetch <= '0;
      st <= E_IDLE; m_we <= 1'b0; m_addr <= '0; m_len <= '0; left <= '0;
      pf_on <= 1'b0; single <= 1'b0; s_done <= 1'b0; s_data <= '0;
    end else begin
      if (acc_wr) wq_wp <= wq_wp + 1'b1;
      if (pop_w)  wq_rp <= wq_rp + 1'b1;
      wf_cnt <= wf_cnt + CW'(acc_wr) - CW'(pop_w);

      if (flush_r) begin
        rq_wp <= '0; rq_rp <= '0; rf_cnt <= '0;
      end else begin
        if (push_r)  rq_wp <= rq_wp + 1'b1;
        if (acc_rdi) rq_rp <= rq_rp + 1'b1;
        rf_cnt <= rf_cnt + CW'(push_r) - CW'(acc_rdi);
      end

      if (acc_ldw) waddr <= h_wdata[AW-1:0];
      if (acc_rdi) ra_host <= ra_host + 1'b1;
      if (acc_rds) s_done <= 1'b0;
      if (h_req && op_rdi && wf_cnt == '0) pf_on <= 1'b1;
      if (acc_ldr) begin
        ra_host <= h_wdata[AW-1:0]; ra_fetch <= h_wdata[AW-1:0]; pf_on <= 1'b0;
      end

      case (st)
        E_IDLE: begin
          if (go_w) begin
            st <= E_REQ; m_we <= 1'b1; m_addr <= waddr; m_len <= wlen; single <= 1'b0;
            waddr <= waddr + AW'(wlen);
          end else if (go_s) begin
            st <= E_REQ; m_we <= 1'b0; m_addr <= ra_host; m_len <= LW'(1); single <= 1'b1;
            pf_on <= 1'b0; ra_fetch <= ra_host;
          end else if (go_p) begin
            st <= E_REQ; m_we <= 1'b0; m_addr <= ra_fetch; m_len <= LW'(BURST); single <= 1'b0;
            ra_fetch <= ra_fetch + AW'(BURST);
          end
        end
        E_REQ: if (m_gnt) begin st <= E_BUSY; left <= m_len; end
        default: if (m_beat) begin
          left <= left - 1'b1;
          if (single) begin s_done <= 1'b1; s_data <= m_rdata; end
          if (left == LW'(1)) st <= E_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/hostq_prefetch_chk.sv
module hostq_prefetch_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int BURST = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       h_req,
  input logic [2:0]                 h_op,
  input logic                       h_ready,
  input logic                       m_req,
  input logic                       m_gnt,
  input logic                       m_we,
  input logic [AW-1:0]              m_addr,
  input logic [$clog2(BURST+1)-1:0] m_len,
  input logic [$clog2(DEPTH+1)-1:0] wf_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rf_cnt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(BURST + 1);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    h_req && h_op == 3'd0 && wf_cnt == CW'(DEPTH) |-> !h_ready);
  p_wlen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_we |-> (m_len != '0) && (m_len <= LW'(BURST)));
  p_drain_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_req && h_op == 3'd3 && wf_cnt != '0 |-> !h_ready);
  p_rlen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_we |-> (m_len == LW'(BURST)) || (m_len == LW'(1)));
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h_req && h_op == 3'd1 && rf_cnt == '0 |-> !h_ready);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_cnt <= CW'(DEPTH));
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_gnt |=> m_req && $stable(m_addr) && $stable(m_len) && $stable(m_we));
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !m_req && wf_cnt == '0 && rf_cnt == '0);
endmodule

bind hostq_prefetch hostq_prefetch_chk #(.AW(AW), .DEPTH(DEPTH), .BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_op(h_op), .h_ready(h_ready),
  .m_req(m_req), .m_gnt(m_gnt), .m_we(m_we), .m_addr(m_addr), .m_len(m_len),
  .wf_cnt(wf_cnt), .rf_cnt(rf_cnt)
);

// File: tb/hostq_prefetch_tb_top.sv
module hostq_prefetch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        h_req = 1'b0;
  logic [2:0]  h_op = 3'd0;
  logic [31:0] h_wdata = '0;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic        m_req, m_we;
  logic [31:0] m_addr;
  logic [2:0]  m_len;
  logic        m_gnt, m_beat;
  logic [31:0] m_wdata, m_rdata;

  hostq_prefetch dut_i (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_op(h_op), .h_wdata(h_wdata),
    .h_ready(h_ready), .h_rdata(h_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_len(m_len), .m_gnt(m_gnt), .m_beat(m_beat),
    .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  int nchk = 0;
  int nfail = 0;
  logic gnt_en = 1'b1;

  logic [31:0] mem [64];
  logic        mbusy, cw;
  int          ca, cl, idx;
  int          rd_bursts, wr_bursts, single_reads, bad_len, last_wlen;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'hA000_0000 + i;
      m_gnt <= 1'b0; m_beat <= 1'b0; m_rdata <= '0; mbusy <= 1'b0; cw <= 1'b0;
      ca <= 0; cl <= 0; idx <= 0;
      rd_bursts <= 0; wr_bursts <= 0; single_reads <= 0; bad_len <= 0; last_wlen <= 0;
    end else if (m_gnt) begin
      m_gnt <= 1'b0; m_beat <= 1'b1; idx <= 0; m_rdata <= mem[ca % 64];
    end else if (m_beat) begin
      if (cw) mem[(ca + idx) % 64] <= m_wdata;
      if (idx + 1 < cl) begin
        m_rdata <= mem[(ca + idx + 1) % 64]; idx <= idx + 1;
      end else begin
        m_beat <= 1'b0; mbusy <= 1'b0;
      end
    end else if (m_req && !mbusy && gnt_en) begin
      m_gnt <= 1'b1; mbusy <= 1'b1; ca <= int'(m_addr); cl <= int'(m_len); cw <= m_we;
      if (m_we) begin wr_bursts <= wr_bursts + 1; last_wlen <= int'(m_len); end
      else if (m_len == 3'd1) single_reads <= single_reads + 1;
      else if (m_len == 3'd4) rd_bursts <= rd_bursts + 1;
      else bad_len <= bad_len + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic [2:0] op, input logic [31:0] d, output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    h_req = 1'b1; h_op = op; h_wdata = d;
    #1;
    while (!h_ready && n < 2000) begin
      @(negedge clk); #1; n++;
    end
    rd = h_rdata;
    if (!h_ready) begin
      nchk++; nfail++;
      $display("FAIL R11 host op %0d never accepted actual=0 expected=1", op);
    end
    @(posedge clk); #1;
    h_req = 1'b0;
  endtask

  // {op, check, data, expected}
  localparam logic [67:0] VEC [14] = '{
    {3'd3, 1'b0, 32'd16,          32'd0},
    {3'd0, 1'b0, 32'h1111_0001,   32'd0},
    {3'd0, 1'b0, 32'h1111_0002,   32'd0},
    {3'd0, 1'b0, 32'h1111_0003,   32'd0},
    {3'd4, 1'b0, 32'd16,          32'd0},
    {3'd1, 1'b1, 32'd0,           32'h1111_0001},
    {3'd1, 1'b1, 32'd0,           32'h1111_0002},
    {3'd1, 1'b1, 32'd0,           32'h1111_0003},
    {3'd1, 1'b1, 32'd0,           32'hA000_0013},
    {3'd2, 1'b1, 32'd0,           32'hA000_0014},
    {3'd1, 1'b1, 32'd0,           32'hA000_0014},
    {3'd4, 1'b0, 32'd40,          32'd0},
    {3'd1, 1'b1, 32'd0,           32'hA000_0028},
    {3'd2, 1'b1, 32'd0,           32'hA000_0029}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [31:0] a0;
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R10 m_req after reset", {31'd0, m_req}, 32'd0);
    check("R10 h_ready after reset", {31'd0, h_ready}, 32'd0);

    // R3 drain-before-read, R6 order, R7 flush, R8 single read, R11 encoding
    for (int i = 0; i < 14; i++) begin
      host_op(VEC[i][67:65], VEC[i][63:32], rd);
      if (VEC[i][64]) check($sformatf("R3 R6 R7 R8 R11 vector %0d", i), rd, VEC[i][31:0]);
    end

    // R4 initial prefetch, R5 refill
    host_op(3'd4, 32'd48, rd);
    repeat (10) @(posedge clk);
    base = rd_bursts;
    host_op(3'd1, 32'd0, rd);
    check("R4 first prefetch word", rd, 32'hA000_0030);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R4 two prefetch bursts", rd_bursts - base, 2);
    for (int i = 1; i < 5; i++) begin
      host_op(3'd1, 32'd0, rd);
      check("R6 prefetched order", rd, 32'hA000_0030 + i);
    end
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R5 refill burst", rd_bursts - base, 3);
    check("R4 read lengths", bad_len, 0);

    // R1 full write queue, R9 command hold, R2 bursts
    gnt_en = 1'b0;
    host_op(3'd3, 32'd56, rd);
    for (int i = 0; i < 8; i++) host_op(3'd0, 32'hB000_0000 + i, rd);
    @(negedge clk);
    h_req = 1'b1; h_op = 3'd0; h_wdata = 32'hDEAD_0000;
    #1;
    check("R1 ninth write refused", {31'd0, h_ready}, 32'd0);
    a0 = m_addr;
    repeat (3) @(negedge clk);
    #1;
    check("R1 still refused", {31'd0, h_ready}, 32'd0);
    check("R9 request held", {31'd0, m_req}, 32'd1);
    check("R9 address stable", m_addr, a0);
    h_req = 1'b0;
    base = wr_bursts;
    gnt_en = 1'b1;
    repeat (80) @(posedge clk);
    @(negedge clk);
    check("R2 two write bursts", wr_bursts - base, 2);
    check("R2 write burst length", last_wlen, 4);
    for (int i = 0; i < 8; i++)
      check("R2 written word", mem[56 + i], 32'hB000_0000 + i);

    // R3 partial drain on address load
    host_op(3'd3, 32'd0, rd);
    host_op(3'd0, 32'hC000_0000, rd);
    host_op(3'd0, 32'hC000_0001, rd);
    host_op(3'd3, 32'd8, rd);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R3 partial burst length", last_wlen, 2);
    check("R3 partial word 0", mem[0], 32'hC000_0000);
    check("R3 partial word 1", mem[1], 32'hC000_0001);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule